// File: doc/BRIEF.md
# Prioritized Interrupt Dispatcher

This block decides, once per instruction boundary of a small processor core, whether an interrupt is taken. It keeps a per-source enable mask, a per-source request register and a master-enable bit. Requests arrive as one-cycle pulses from peripherals, or are loaded through a register write. A source counts as pending when its request bit and its enable bit are both set.

When the core signals a boundary while master enable is on and at least one source is pending, the block issues a one-cycle take pulse. With that pulse it presents the vector address of the winning source and its index. In the same update it drops master enable, cancels any deferred enable, and clears the request bit of the source it serviced. The core turns the take pulse into its own stack push and jump.

The core sends three commands. The deferred-enable command arms master enable for the following boundary. The disable command turns master enable off at once. The return command turns master enable on at once. A halt request puts the core to sleep only when nothing is pending. A wake output tells a sleeping core that an enabled source has become pending.

Top module: `irq_dispatch`

## Requirements
- R1: When `boundary_i` is high, master enable is 1 and at least one source is pending, `take_o` is high for exactly the next cycle and `src_o` holds the lowest-numbered pending source index. No take happens in a cycle without `boundary_i`.
- R2: During a take, `vector_o` equals 0x40 + 8 × `src_o`.
- R3: A take clears master enable and any deferred enable, and clears only the serviced bit of the request register. In a cycle where a take happens, the commands are ignored.
- R4: `cmd_ei_i` does not change master enable at once. Master enable becomes 1 at the next boundary, and no interrupt is taken at that boundary even if a source is pending.
- R5: `cmd_di_i` clears master enable and the deferred enable at the next clock edge. A following boundary neither sets master enable nor takes an interrupt.
- R6: `cmd_reti_i` sets master enable at the next clock edge, with no boundary needed.
- R7: Pending is the bitwise AND of `enable_o` and `request_o`. A requested but disabled source is never taken.
- R8: A high bit of `irq_pulse_i` sets that request bit. A write with `reg_wr_sel_i`=0 loads the enable mask and with `reg_wr_sel_i`=1 loads the request register. A pulse on a bit wins over a write or a clear of that bit in the same cycle.
- R9: `halt_enter_i` sets `halted_o` only if nothing is pending. `wake_o` is high while `halted_o` is high and a source is pending, and `halted_o` falls at the following edge.
- R10: After reset, master enable, deferred enable, `halted_o`, `take_o`, `src_o`, `vector_o`, the enable mask and the request register are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pulse_i | input | N | One-cycle request pulses from sources |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wr_sel_i | input | 1 | Write target: 0 enable mask, 1 request register |
| reg_wr_data_i | input | N | Write data |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| cmd_ei_i | input | 1 | Deferred-enable command |
| cmd_di_i | input | 1 | Disable command |
| cmd_reti_i | input | 1 | Return command, enables at once |
| halt_enter_i | input | 1 | Core requests to halt |
| take_o | output | 1 | One-cycle interrupt take pulse |
| vector_o | output | ADDR_W | Vector address of the taken source |
| src_o | output | IDX_W | Index of the taken source |
| master_en_o | output | 1 | Master enable state |
| halted_o | output | 1 | Core is held halted |
| wake_o | output | 1 | Halted and an enabled source is pending |
| enable_o | output | N | Enable mask contents |
| request_o | output | N | Request register contents |

## Verification
The hardest case to reach is the deferred enable. A source must already be pending while master enable is off, and the bench must then watch two boundaries in a row. The first boundary must only turn the enable on. The second boundary must take the interrupt. The stimulus loads the masks first, issues the command, and then drives boundaries on consecutive cycles while sampling the take pulse after each one. A similar sequence checks that a take also cancels a deferred enable: the return command and the deferred-enable command are given before a take, and a further boundary must leave master enable off.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

    typedef enum logic {
        WSEL_ENABLE  = 1'b0,
        WSEL_REQUEST = 1'b1
    } wr_target_e;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     pend_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        any_o = |pend_i;
        idx_o = '0;
        // scan high to low so the lowest set bit is written last
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
    parameter int IDX_W     = 3,
    parameter int ADDR_W    = 16,
    parameter int VEC_BASE  = 64,
    parameter int VEC_SHIFT = 3
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] vec_o
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(VEC_BASE);

    always_comb begin
        vec_o = BASE_A + (ADDR_W'(idx_i) << VEC_SHIFT);
    end

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_dispatch_pkg::*;
#(
    parameter int N         = 5,
    parameter int ADDR_W    = 16,
    parameter int VEC_BASE  = 64,
    parameter int VEC_SHIFT = 3,
    localparam int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      irq_pulse_i,
    input  logic              reg_wr_i,
    input  logic              reg_wr_sel_i,
    input  logic [N-1:0]      reg_wr_data_i,
    input  logic              boundary_i,
    input  logic              cmd_ei_i,
    input  logic              cmd_di_i,
    input  logic              cmd_reti_i,
    input  logic              halt_enter_i,
    output logic              take_o,
    output logic [ADDR_W-1:0] vector_o,
    output logic [IDX_W-1:0]  src_o,
    output logic              master_en_o,
    output logic              halted_o,
    output logic              wake_o,
    output logic [N-1:0]      enable_o,
    output logic [N-1:0]      request_o
);

    typedef struct packed {
        logic [N-1:0]      en;
        logic [N-1:0]      req;
        logic              ime;
        logic              arm;
        logic              halted;
        logic              take;
        logic [IDX_W-1:0]  src;
        logic [ADDR_W-1:0] vec;
    } state_t;

    state_t s_d, s_q;

    logic [N-1:0]      pend_w;
    logic              any_w;
    logic [IDX_W-1:0]  idx_w;
    logic [ADDR_W-1:0] vec_w;
    logic              take_now_w;
    logic [N-1:0]      clr_w;
    logic [N-1:0]      req_base_w;
    wr_target_e        wsel_w;

    assign pend_w = s_q.en & s_q.req;

    irq_prio_pick #(
        .N     (N),
        .IDX_W (IDX_W)
    ) u_pick (
        .pend_i (pend_w),
        .any_o  (any_w),
        .idx_o  (idx_w)
    );

    irq_vec_map #(
        .IDX_W     (IDX_W),
        .ADDR_W    (ADDR_W),
        .VEC_BASE  (VEC_BASE),
        .VEC_SHIFT (VEC_SHIFT)
    ) u_vec (
        .idx_i (idx_w),
        .vec_o (vec_w)
    );

    assign take_now_w = boundary_i & s_q.ime & any_w;
    assign wsel_w     = wr_target_e'(reg_wr_sel_i);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_clr
            assign clr_w[g] = take_now_w && (idx_w == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        s_d      = s_q;
        s_d.take = 1'b0;

        // enable mask load
        if (reg_wr_i && wsel_w == WSEL_ENABLE) begin
            s_d.en = reg_wr_data_i;
        end

        // request register: load, then service clear, then pulses win
        req_base_w = (reg_wr_i && wsel_w == WSEL_REQUEST) ? reg_wr_data_i : s_q.req;
        s_d.req    = (req_base_w & ~clr_w) | irq_pulse_i;

        if (take_now_w) begin
            s_d.take = 1'b1;
            s_d.src  = idx_w;
            s_d.vec  = vec_w;
            s_d.ime  = 1'b0;
            s_d.arm  = 1'b0;
        end else begin
            if (boundary_i && s_q.arm) begin
                s_d.ime = 1'b1;
                s_d.arm = 1'b0;
            end
            if (cmd_ei_i) begin
                s_d.arm = 1'b1;
            end
            if (cmd_reti_i) begin
                s_d.ime = 1'b1;
                s_d.arm = 1'b0;
            end
            if (cmd_di_i) begin
                s_d.ime = 1'b0;
                s_d.arm = 1'b0;
            end
        end

        if (halt_enter_i && !any_w) begin
            s_d.halted = 1'b1;
        end else if (any_w) begin
            s_d.halted = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign take_o      = s_q.take;
    assign vector_o    = s_q.vec;
    assign src_o       = s_q.src;
    assign master_en_o = s_q.ime;
    assign halted_o    = s_q.halted;
    assign wake_o      = s_q.halted & any_w;
    assign enable_o    = s_q.en;
    assign request_o   = s_q.req;

endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
    parameter int ADDR_W    = 16,
    parameter int VEC_BASE  = 64,
    parameter int VEC_SHIFT = 3,
    parameter int IDX_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary_i,
    input logic              cmd_ei_i,
    input logic              cmd_di_i,
    input logic              cmd_reti_i,
    input logic              take_o,
    input logic [ADDR_W-1:0] vector_o,
    input logic [IDX_W-1:0]  src_o,
    input logic              master_en_o,
    input logic              halted_o,
    input logic              wake_o
);

    a_r1_take_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($past(boundary_i) && $past(master_en_o)));

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    a_r2_vector_map: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vector_o == ADDR_W'(VEC_BASE) + (ADDR_W'(src_o) << VEC_SHIFT)));

    a_r3_take_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !master_en_o);

    a_r4_ei_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ei_i && !master_en_o && !cmd_reti_i && !boundary_i) |=> !master_en_o);

    a_r5_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_di_i |=> !master_en_o);

    a_r6_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reti_i && !cmd_di_i && !boundary_i) |=> master_en_o);

    a_r9_wake_releases: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !halted_o);

    a_r9_wake_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> halted_o);

endmodule

bind irq_dispatch irq_dispatch_chk #(
    .ADDR_W    (ADDR_W),
    .VEC_BASE  (VEC_BASE),
    .VEC_SHIFT (VEC_SHIFT),
    .IDX_W     (IDX_W)
) u_chk (.*);

// File: tb/irq_dispatch_tb.sv
module irq_dispatch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 5;
    localparam int ADDR_W     = 16;
    localparam int IDX_W      = 3;
    localparam int NVEC       = 8;

    // {enable[15:11], request[10:6], expect_take[5], expect_idx[4:2], pad[1:0]}
    localparam logic [15:0] VECS [NVEC] = '{
        {5'h1F, 5'h01, 1'b1, 3'd0, 2'b00},
        {5'h1F, 5'h10, 1'b1, 3'd4, 2'b00},
        {5'h1F, 5'h18, 1'b1, 3'd3, 2'b00},
        {5'h06, 5'h1C, 1'b1, 3'd2, 2'b00},
        {5'h1C, 5'h03, 1'b0, 3'd0, 2'b00},
        {5'h1F, 5'h00, 1'b0, 3'd0, 2'b00},
        {5'h10, 5'h1F, 1'b1, 3'd4, 2'b00},
        {5'h0A, 5'h0E, 1'b1, 3'd1, 2'b00}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      irq_pulse_i = '0;
    logic              reg_wr_i = 1'b0;
    logic              reg_wr_sel_i = 1'b0;
    logic [N-1:0]      reg_wr_data_i = '0;
    logic              boundary_i = 1'b0;
    logic              cmd_ei_i = 1'b0;
    logic              cmd_di_i = 1'b0;
    logic              cmd_reti_i = 1'b0;
    logic              halt_enter_i = 1'b0;
    logic              take_o;
    logic [ADDR_W-1:0] vector_o;
    logic [IDX_W-1:0]  src_o;
    logic              master_en_o;
    logic              halted_o;
    logic              wake_o;
    logic [N-1:0]      enable_o;
    logic [N-1:0]      request_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_dispatch u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_pulse_i   (irq_pulse_i),
        .reg_wr_i      (reg_wr_i),
        .reg_wr_sel_i  (reg_wr_sel_i),
        .reg_wr_data_i (reg_wr_data_i),
        .boundary_i    (boundary_i),
        .cmd_ei_i      (cmd_ei_i),
        .cmd_di_i      (cmd_di_i),
        .cmd_reti_i    (cmd_reti_i),
        .halt_enter_i  (halt_enter_i),
        .take_o        (take_o),
        .vector_o      (vector_o),
        .src_o         (src_o),
        .master_en_o   (master_en_o),
        .halted_o      (halted_o),
        .wake_o        (wake_o),
        .enable_o      (enable_o),
        .request_o     (request_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock: inputs were set after a falling edge; sample after the next one
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        irq_pulse_i  = '0;
        reg_wr_i     = 1'b0;
        boundary_i   = 1'b0;
        cmd_ei_i     = 1'b0;
        cmd_di_i     = 1'b0;
        cmd_reti_i   = 1'b0;
        halt_enter_i = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [N-1:0] data);
        reg_wr_i = 1'b1; reg_wr_sel_i = sel; reg_wr_data_i = data;
        cyc();
    endtask

    task automatic clean();
        cmd_di_i = 1'b1;
        cyc();
        wr(1'b1, '0);
        wr(1'b0, '0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 take", 32'(take_o), 0);
        check("R10 master", 32'(master_en_o), 0);
        check("R10 halted", 32'(halted_o), 0);
        check("R10 vector", 32'(vector_o), 0);
        check("R10 src", 32'(src_o), 0);
        check("R10 enable", 32'(enable_o), 0);
        check("R10 request", 32'(request_o), 0);

        // table: R1, R2, R3, R6, R7
        for (int k = 0; k < NVEC; k++) begin
            logic [N-1:0] en_v, rq_v;
            logic         tk;
            logic [2:0]   ix;
            en_v = VECS[k][15:11];
            rq_v = VECS[k][10:6];
            tk   = VECS[k][5];
            ix   = VECS[k][4:2];
            wr(1'b0, en_v);
            wr(1'b1, rq_v);
            cmd_reti_i = 1'b1;
            cyc();
            check("R6 reti enables", 32'(master_en_o), 1);
            boundary_i = 1'b1;
            cyc();
            check("R1 R7 take", 32'(take_o), 32'(tk));
            if (tk) begin
                check("R1 lowest src", 32'(src_o), 32'(ix));
                check("R2 vector", 32'(vector_o), 32'h40 + 32'(ix) * 8);
                check("R3 master off", 32'(master_en_o), 0);
                check("R3 serviced bit", 32'(request_o), 32'(rq_v & ~(5'b1 << ix)));
            end else begin
                check("R7 request kept", 32'(request_o), 32'(rq_v));
            end
            cyc();
            check("R1 pulse one cycle", 32'(take_o), 0);
            clean();
        end

        // R4 deferred enable
        wr(1'b0, 5'h1F);
        wr(1'b1, 5'h01);
        cmd_ei_i = 1'b1;
        cyc();
        check("R4 not immediate", 32'(master_en_o), 0);
        boundary_i = 1'b1;
        cyc();
        check("R4 no take on arming boundary", 32'(take_o), 0);
        check("R4 armed", 32'(master_en_o), 1);
        boundary_i = 1'b1;
        cyc();
        check("R4 take next boundary", 32'(take_o), 1);
        check("R4 src", 32'(src_o), 0);
        clean();

        // R3 take cancels a deferred enable
        wr(1'b0, 5'h1F);
        wr(1'b1, 5'h03);
        cmd_reti_i = 1'b1;
        cyc();
        cmd_ei_i = 1'b1;
        cyc();
        boundary_i = 1'b1;
        cyc();
        check("R3 take", 32'(take_o), 1);
        check("R3 request left", 32'(request_o), 32'h02);
        boundary_i = 1'b1;
        cyc();
        check("R3 arm cleared", 32'(master_en_o), 0);
        check("R3 no second take", 32'(take_o), 0);
        clean();

        // R5 disable cancels both
        wr(1'b0, 5'h1F);
        wr(1'b1, 5'h04);
        cmd_reti_i = 1'b1;
        cyc();
        cmd_ei_i = 1'b1;
        cyc();
        cmd_di_i = 1'b1;
        cyc();
        check("R5 master off", 32'(master_en_o), 0);
        boundary_i = 1'b1;
        cyc();
        check("R5 boundary no enable", 32'(master_en_o), 0);
        check("R5 boundary no take", 32'(take_o), 0);
        clean();

        // R1 no take without boundary
        wr(1'b0, 5'h1F);
        wr(1'b1, 5'h08);
        cmd_reti_i = 1'b1;
        cyc();
        for (int j = 0; j < 4; j++) begin
            cyc();
            check("R1 no boundary no take", 32'(take_o), 0);
        end
        clean();

        // R8 pulses and writes
        irq_pulse_i = 5'h04;
        cyc();
        check("R8 pulse sets", 32'(request_o), 32'h04);
        reg_wr_i = 1'b1; reg_wr_sel_i = 1'b1; reg_wr_data_i = 5'h00; irq_pulse_i = 5'h02;
        cyc();
        check("R8 pulse beats write", 32'(request_o), 32'h02);
        wr(1'b0, 5'h15);
        check("R8 enable write", 32'(enable_o), 32'h15);
        check("R8 request untouched", 32'(request_o), 32'h02);
        clean();

        // R9 halt and wake
        wr(1'b0, 5'h08);
        halt_enter_i = 1'b1;
        cyc();
        check("R9 halted", 32'(halted_o), 1);
        check("R9 no wake", 32'(wake_o), 0);
        irq_pulse_i = 5'h01;
        cyc();
        check("R9 disabled source no wake", 32'(wake_o), 0);
        irq_pulse_i = 5'h08;
        cyc();
        check("R9 wake", 32'(wake_o), 1);
        check("R9 still halted", 32'(halted_o), 1);
        cyc();
        check("R9 released", 32'(halted_o), 0);
        halt_enter_i = 1'b1;
        cyc();
        check("R9 halt refused while pending", 32'(halted_o), 0);
        clean();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule